// File: doc/BRIEF.md
# Clock-Ratio Detector with Soft Mute

This block sits in the master-clock domain of an audio output path. It synchronises the frame (sample-rate) clock and counts master-clock cycles between successive rising frame edges. It then classifies each measured period as one of the supported master-to-frame ratios (256, 384 or 512) or as unsupported. The detector reports a ratio as valid only after several frames in a row agree on the same value. Any disagreement, unsupported period or missing frame edge withdraws validity at once.

Validity drives a gain stage that scales a stereo sample stream. While the clocks are not valid, the gain is zero and the samples leave as an exact zero code. Once validity is established, the gain climbs by one step per frame from zero to unity. Because the ramp is counted in frames, its duration follows the sample rate: with the default 10-bit fraction it lasts 1024 frames, about 21 ms at 48 kHz. A mute in the middle of a ramp drops the gain straight to zero, and the next ramp starts again from zero.

Top module: `clk_ratio_mute`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `ratio_valid`, `ratio_code`, `out_valid`, `out_left` and `out_right` are all zero.
- R2: A measured period within ±TOL master-clock cycles of 256, 384 or 512 is classified as code 1, 2 or 3 respectively. Any other period gives code 0 and clears `ratio_valid`. The default TOL is 1.
- R3: A period is the number of master-clock cycles between two successive rising frame edges. The first edge after reset or after a clock loss only starts a measurement. `ratio_valid` rises on the edge that completes QUAL_FRAMES (default 4) consecutive periods with the same nonzero code. While valid, `ratio_code` shows that code, and it is 0 otherwise.
- R4: A period that classifies to a supported code different from the one being qualified clears `ratio_valid` on that frame edge, and qualification restarts with a count of one.
- R5: If no rising frame edge arrives within LOSS_CYC master-clock cycles of the previous one, `ratio_valid` drops to 0 and `ratio_code` drops to 0.
- R6: While `ratio_valid` is 0, apart from a pipeline of two cycles after it falls, both output samples are exactly zero.
- R7: The gain is 0 on the frame edge where validity is established. It rises by exactly one step on each later frame edge while valid, and it saturates at unity (2^GAIN_W), where each output sample equals its input.
- R8: Each output equals sign(x)·floor(|x|·g / 2^GAIN_W) for input x and current gain g, which truncates toward zero and keeps the sign. The output is registered, one cycle after the input, and `out_valid` repeats `in_valid` one cycle later.
- R9: When validity is lost during a ramp, the gain falls to zero immediately. After the next successful qualification the ramp restarts from zero, not from the gain it had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Frame (sample-rate) clock, asynchronous to `clk` |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | SAMPLE_W | Gain-scaled left sample |
| out_right | output | SAMPLE_W | Gain-scaled right sample |
| ratio_code | output | 2 | Qualified ratio: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| ratio_valid | output | 1 | Clocks qualified as valid |

## Verification
The frame clock is driven at each supported ratio. This shows that the three codes are told apart and that the ramp length depends only on the number of frames. Periods one count off the nominal value are accepted, a period two counts off is rejected, and an unsupported ratio never qualifies. Switching ratio and removing the frame clock mid-ramp separate a mismatch clear from a loss clear, and both confirm that the ramp restarts at zero. At every gain step of a full ramp, a fixed set of sample values is applied: zero, ±1, mid-range values, the largest positive value and the most negative value. This set exposes rounding direction, sign handling and the unity end point.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_256  = 2'd1,
    RC_384  = 2'd2,
    RC_512  = 2'd3
  } ratio_code_t;
endpackage

// File: rtl/cr_edge_sync.sv
module cr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      rise <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-1:0], async_in};
      rise <= sh[STAGES-1] & ~sh[STAGES];
    end
  end
endmodule

// File: rtl/cr_ratio_meter.sv
module cr_ratio_meter
  import cr_pkg::*;
#(
  parameter int LOSS_CYC    = 1024,
  parameter int QUAL_FRAMES = 4,
  parameter int TOL         = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  output logic        valid,
  output ratio_code_t code
);
  localparam int CNT_W = $clog2(LOSS_CYC + 1);
  localparam int MW    = $clog2(QUAL_FRAMES + 1);

  logic [CNT_W-1:0] cnt;
  logic [MW-1:0]    match, match_nx;
  ratio_code_t      last, cur;
  logic             valid_nx, lost;

  function automatic ratio_code_t classify(input logic [CNT_W-1:0] n);
    int v;
    v = int'(n);
    if (v + TOL >= 256 && v <= 256 + TOL) return RC_256;
    if (v + TOL >= 384 && v <= 384 + TOL) return RC_384;
    if (v + TOL >= 512 && v <= 512 + TOL) return RC_512;
    return RC_NONE;
  endfunction

  assign lost = (cnt == CNT_W'(LOSS_CYC));

  always_comb begin
    cur      = classify(cnt);
    match_nx = '0;
    if (cur != RC_NONE) begin
      if (cur == last)
        match_nx = (match == MW'(QUAL_FRAMES)) ? match : match + 1'b1;
      else
        match_nx = MW'(1);
    end
    valid_nx = (cur != RC_NONE) && (match_nx == MW'(QUAL_FRAMES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= CNT_W'(LOSS_CYC);
      match <= '0;
      last  <= RC_NONE;
      valid <= 1'b0;
      code  <= RC_NONE;
    end else if (tick) begin
      cnt   <= CNT_W'(1);
      match <= match_nx;
      last  <= cur;
      valid <= valid_nx;
      code  <= valid_nx ? cur : RC_NONE;
    end else if (!lost) begin
      cnt <= cnt + 1'b1;
    end else begin
      match <= '0;
      last  <= RC_NONE;
      valid <= 1'b0;
      code  <= RC_NONE;
    end
  end

  // R3
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(tick));

  // R5
  loss_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (lost && !tick) |=> !valid);
endmodule

// File: rtl/cr_gain_scale.sv
module cr_gain_scale #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic                     enable,
  input  logic                     in_valid,
  input  logic [1:0][SAMPLE_W-1:0] in_smp,
  output logic                     out_valid,
  output logic [1:0][SAMPLE_W-1:0] out_smp
);
  localparam int GW1 = GAIN_W + 1;
  localparam int PW  = SAMPLE_W + GW1;
  localparam logic [GAIN_W:0] UNITY = GW1'(1) << GAIN_W;

  logic [GAIN_W:0] gain;

  always_ff @(posedge clk) begin
    if (rst)                         gain <= '0;
    else if (!enable)                gain <= '0;
    else if (tick && gain != UNITY)  gain <= gain + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] mag, scaled;
    logic [PW-1:0]       prod;
    logic                neg;

    always_comb begin
      neg    = in_smp[ch][SAMPLE_W-1];
      mag    = neg ? (~in_smp[ch] + 1'b1) : in_smp[ch];
      prod   = PW'(mag) * PW'(gain);
      scaled = prod[GAIN_W +: SAMPLE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) out_smp[ch] <= '0;
      else     out_smp[ch] <= neg ? (~scaled + 1'b1) : scaled;
    end

    // R8
    sign_kept_chk: assert property (@(posedge clk) disable iff (rst)
      (out_smp[ch] != '0) |-> out_smp[ch][SAMPLE_W-1] == $past(in_smp[ch][SAMPLE_W-1]));
  end

  // R7
  gain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (gain != $past(gain)) |->
      (gain == '0) || ((gain == $past(gain) + 1'b1) && $past(tick) && $past(enable)));
endmodule

// File: rtl/clk_ratio_mute.sv
module clk_ratio_mute #(
  parameter int SAMPLE_W    = 24,
  parameter int GAIN_W      = 10,
  parameter int LOSS_CYC    = 1024,
  parameter int QUAL_FRAMES = 4,
  parameter int TOL         = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_clk,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic [1:0]          ratio_code,
  output logic                ratio_valid
);
  import cr_pkg::*;

  logic                     frame_tick;
  ratio_code_t              code_q;
  logic [1:0][SAMPLE_W-1:0] smp_in, smp_out;

  cr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(frame_clk), .rise(frame_tick)
  );

  cr_ratio_meter #(.LOSS_CYC(LOSS_CYC), .QUAL_FRAMES(QUAL_FRAMES), .TOL(TOL)) u_meter (
    .clk(clk), .rst(rst), .tick(frame_tick), .valid(ratio_valid), .code(code_q)
  );

  assign smp_in = {in_right, in_left};

  cr_gain_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_gain (
    .clk(clk), .rst(rst), .tick(frame_tick), .enable(ratio_valid),
    .in_valid(in_valid), .in_smp(smp_in),
    .out_valid(out_valid), .out_smp(smp_out)
  );

  assign out_left   = smp_out[0];
  assign out_right  = smp_out[1];
  assign ratio_code = code_q;

  // R6
  mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!ratio_valid && !$past(ratio_valid) && !$past(ratio_valid, 2))
      |-> (out_left == '0 && out_right == '0));

  // R2
  code_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ratio_valid |-> ratio_code != 2'd0);
endmodule

// File: tb/clk_ratio_mute_bench.sv
module clk_ratio_mute_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW    = 16;
  localparam int GW    = 4;
  localparam int UNITY = 16;
  localparam int QUAL  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_clk = 1'b0;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_left = '0, in_right = '0;
  logic          out_valid;
  logic [SW-1:0] out_left, out_right;
  logic [1:0]    ratio_code;
  logic          ratio_valid;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // model of the requirements at frame granularity
  int m_prev = 0, m_last = 0, m_match = 0, m_gain = 0;
  bit m_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ratio_mute #(.SAMPLE_W(SW), .GAIN_W(GW)) u_clk_ratio_mute (
    .clk(clk), .rst(rst), .frame_clk(frame_clk), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right),
    .ratio_code(ratio_code), .ratio_valid(ratio_valid)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int classify(int v);
    if (v >= 255 && v <= 257) return 1;
    if (v >= 383 && v <= 385) return 2;
    if (v >= 511 && v <= 513) return 3;
    return 0;
  endfunction

  function automatic longint sval(int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return -1;
      3: return 100;
      4: return -100;
      5: return 32767;
      6: return -32768;
      default: return -12345;
    endcase
  endfunction

  function automatic longint scale(longint s, int g);
    if (s < 0) return -(((-s) * g) / UNITY);
    return (s * g) / UNITY;
  endfunction

  task automatic drive(int i);
    in_left  = SW'(sval(i));
    in_right = SW'(sval(7 - i));
  endtask

  task automatic check_samp(int i);
    string tag;
    longint el, er;
    tag = (m_gain == 0) ? "R6" : ((m_gain == UNITY) ? "R7" : "R8");
    el = scale(sval(i), m_gain);
    er = scale(sval(7 - i), m_gain);
    chk(out_valid == 1'b1, "R8", "out_valid", out_valid, 1);
    chk(longint'($signed(out_left)) == el, tag, "left sample", longint'($signed(out_left)), el);
    chk(longint'($signed(out_right)) == er, tag, "right sample", longint'($signed(out_right)), er);
  endtask

  task automatic check_status(string tag);
    int ec;
    ec = m_valid ? m_last : 0;
    chk(ratio_valid == m_valid, tag, "ratio_valid", ratio_valid, m_valid);
    chk(int'(ratio_code) == ec, tag, "ratio_code", ratio_code, ec);
  endtask

  // one frame of the given length in master-clock cycles
  task automatic frame(int len, string tag);
    int cd;
    bit old_v;
    cd = classify(m_prev);
    old_v = m_valid;
    if (cd == 0) begin
      m_match = 0; m_valid = 1'b0;
    end else if (cd == m_last) begin
      if (m_match < QUAL) m_match++;
      m_valid = (m_match == QUAL);
    end else begin
      m_match = 1; m_valid = 1'b0;
    end
    m_last = cd;
    if (!m_valid) m_gain = 0;
    else if (old_v && m_gain < UNITY) m_gain++;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      frame_clk = (c < len / 2);
      if (c >= 21 && c <= 28) check_samp(c - 21);
      if (c >= 20 && c <= 27) drive(c - 20);
      if (c == 30) check_status(tag);
    end
    m_prev = len;
  endtask

  // R5: frame clock stops for longer than the loss window
  task automatic idle(int n);
    frame_clk = 1'b0;
    drive(5);
    for (int c = 0; c < n; c++) @(negedge clk);
    m_prev = 0; m_last = 0; m_match = 0; m_valid = 1'b0; m_gain = 0;
    check_status("R5");
    chk(out_left == '0 && out_right == '0, "R6", "muted after loss",
        longint'($signed(out_left)), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    drive(5);
    repeat (5) @(negedge clk);
    // R1
    chk(ratio_valid == 1'b0, "R1", "reset valid", ratio_valid, 0);
    chk(ratio_code == 2'd0, "R1", "reset code", ratio_code, 0);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(out_left == '0 && out_right == '0, "R1", "reset samples",
        longint'($signed(out_left)), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ratio_valid == 1'b0 && out_left == '0, "R1", "after release", ratio_valid, 0);

    // R3 qualification at 256, then R7 full ramp with every gain step
    for (int f = 0; f < 5; f++) frame(256, "R3");
    for (int f = 0; f < 18; f++) frame(256, "R7");

    // R4 ratio change clears validity, requalifies at 384
    for (int f = 0; f < 7; f++) frame(384, "R4");

    // R2 unsupported ratio never qualifies
    for (int f = 0; f < 6; f++) frame(320, "R2");

    // R2 tolerance of one count around 512, then a period two counts off
    for (int f = 0; f < 3; f++) begin
      frame(511, "R2");
      frame(513, "R2");
    end
    frame(514, "R2");
    frame(512, "R2");
    frame(512, "R2");

    // R9 loss in the middle of a ramp, ramp restarts from zero
    for (int f = 0; f < 6; f++) frame(512, "R9");
    idle(1200);
    for (int f = 0; f < 10; f++) frame(512, "R9");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule